// File: doc/BRIEF.md
# Subranging Converter Correction Pipeline

This block is the digital back end of a two-step subranging converter. On every active edge of the sample clock it captures a 5-bit coarse code, a 6-bit fine code and two comparator flags. One flag marks an input above full scale and the other marks an input below negative full scale. The coarse and fine stages overlap by one bit. The block folds the 11 raw bits into one 10-bit two's complement word, and the redundant bit absorbs any overlap error between the stages. An out-of-range input or arithmetic overflow forces the word to the nearest rail and raises an out-of-range flag.

Results leave through a fixed-latency pipeline, and the out-of-range flag travels in step with the data word. A clock-enable input stands for the converter clock. While the enable is low the clock counts as stopped: the pipeline freezes and its contents are treated as stale. The result-valid output stays low until the pipeline has been refilled with fresh samples. An offset-binary output mode inverts the sign bit of the word.

Top module: `subrange_corrector`

## Requirements
- R1: The corrected value is coarse×32 + fine − 16 − 512, taken as a 10-bit two's complement word. For example, coarse 16 with fine 16 gives 0x000.
- R2: A sample captured on an edge where clkEn is high appears on dataOut and oorOut just after the third following edge where clkEn is high.
- R3: When overRange is 1, the word is 0x1FF and oorOut is 1. overRange wins when both comparator flags are 1.
- R4: When underRange is 1 and overRange is 0, the word is 0x200 and oorOut is 1.
- R5: If no comparator flag is set, a computed value above 511 gives 0x1FF, and a value below −512 gives 0x200, with oorOut 1 in both cases. Values from −512 to 511, the end points included, pass unchanged with oorOut 0.
- R6: An in-range sample that follows an out-of-range sample converts normally with oorOut 0, and needs no reset or other sequence.
- R7: Any edge where clkEn is low flushes the pipeline. validOut is then 0 after that edge. While validOut is 0, dataOut and oorOut both read 0.
- R8: Once clkEn is high again, validOut becomes 1 after the fourth consecutive edge with clkEn high. The first valid result is the sample captured on the first of those edges.
- R9: A synchronous active-high rst clears every pipeline stage. After a reset edge, validOut, oorOut and dataOut are 0.
- R10: When offsetBin is 1, bit 9 of dataOut is inverted while validOut is 1. The effect is combinational and shows in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clkEn | input | 1 | High on edges that count as conversion edges; low means the clock has stopped |
| coarseCode | input | 5 | Coarse quantizer code, unsigned |
| fineCode | input | 6 | Fine quantizer code, unsigned, with one bit of overlap |
| overRange | input | 1 | Comparator flag: input above full scale |
| underRange | input | 1 | Comparator flag: input below negative full scale |
| offsetBin | input | 1 | 1 selects offset-binary output (sign bit inverted) |
| dataOut | output | 10 | Corrected, saturated result; 0 while invalid |
| oorOut | output | 1 | Out-of-range flag aligned with dataOut; 0 while invalid |
| validOut | output | 1 | 1 when dataOut holds a sample taken since the last restart |

## Verification
Some properties hold on every cycle, and the assertions watch these. Output registers hold steady on edges where clkEn is low. An edge with clkEn low always empties the valid chain. A rising validOut always follows an uninterrupted run of enabled edges, at least as long as the pipeline. A reset edge leaves validOut low. An asserted oorOut always sits at one of the two rails. The bench shows what only concrete scenarios can: the exact arithmetic of the merge, including carry and borrow out of the fine stage, and that each sample lands on the third enabled edge after capture. It also checks the rail end points, the flag priority, that the first valid word after a restart comes from the right sample, and the sign-bit inversion in offset-binary mode.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

  // Pipeline registers between capture and output, capture stage included.
  localparam int PIPE_STAGES = 4;

  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic advance;  // move every stage forward on this edge
    logic flush;    // clock treated as stopped: contents are stale
  } strobe_t;

endpackage

// File: rtl/subrange_ctrl.sv
module subrange_ctrl
  import subrange_pkg::*;
#(
  parameter int DEPTH = PIPE_STAGES
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clkEn,
  output strobe_t strobes,
  output logic    resultValid
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] validChain;

  always_comb begin
    strobes.advance = clkEn;
    strobes.flush   = ~clkEn;
  end

  // One valid bit per stage. A stall discards them all.
  always_ff @(posedge clk) begin
    if (rst) begin
      validChain <= '0;
    end else if (strobes.flush) begin
      validChain <= '0;
    end else begin
      validChain <= {validChain[DEPTH-2:0], 1'b1};
    end
  end

  assign resultValid = validChain[DEPTH-1];

  // Length of the current run of enabled edges, saturating at DEPTH; used by the checks.
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst || !clkEn) begin
      runCnt <= '0;
    end else if (runCnt != CNT_W'(DEPTH)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R7: a stopped clock leaves no valid result behind it
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.flush |=> !resultValid);

  // R8: valid comes back only after a full run of enabled edges
  p_refill_run_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(resultValid) |-> (runCnt == CNT_W'(DEPTH)));

  // R9: a reset edge leaves the result invalid
  p_reset_invalid_r9: assert property (@(posedge clk)
    rst |=> !resultValid);

endmodule

// File: rtl/subrange_datapath.sv
module subrange_datapath
  import subrange_pkg::*;
#(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 6,
  localparam int OUT_W   = COARSE_W + FINE_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobes,
  input  logic [COARSE_W-1:0] coarseIn,
  input  logic [FINE_W-1:0]   fineIn,
  input  logic                overIn,
  input  logic                underIn,
  output logic [OUT_W-1:0]    wordQ,
  output logic                oorQ
);

  localparam int SUM_W     = OUT_W + 2;
  localparam int MID       = 1 << (OUT_W - 1);
  localparam int FINE_BIAS = 1 << (FINE_W - 2);
  localparam logic signed [SUM_W-1:0] MID_OFF  = SUM_W'(MID);
  localparam logic signed [SUM_W-1:0] BIAS_OFF = SUM_W'(FINE_BIAS);
  localparam logic signed [SUM_W-1:0] TOP_VAL  = SUM_W'(MID - 1);
  localparam logic signed [SUM_W-1:0] BOT_VAL  = -SUM_W'(MID);
  localparam logic [OUT_W-1:0] POS_RAIL = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_RAIL = {1'b1, {(OUT_W-1){1'b0}}};

  // Stage 1: capture the raw quantizer codes and comparator flags.
  logic [COARSE_W-1:0] coarseS1;
  logic [FINE_W-1:0]   fineS1;
  logic                hiS1, loS1;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseS1 <= '0;
      fineS1   <= '0;
      hiS1     <= 1'b0;
      loS1     <= 1'b0;
    end else if (strobes.advance) begin
      coarseS1 <= coarseIn;
      fineS1   <= fineIn;
      hiS1     <= overIn;
      loS1     <= underIn;
    end
  end

  // Stage 2: weight the coarse code and recentre it; remove the fine-stage overlap bias.
  logic signed [SUM_W-1:0] coarseTerm, fineTerm;
  logic signed [SUM_W-1:0] coarseNext, fineNext;
  logic                    hiS2, loS2;

  always_comb begin
    coarseNext = $signed({{(SUM_W-COARSE_W-FINE_W+1){1'b0}}, coarseS1,
                          {(FINE_W-1){1'b0}}}) - MID_OFF;
    fineNext   = $signed({{(SUM_W-FINE_W){1'b0}}, fineS1}) - BIAS_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseTerm <= '0;
      fineTerm   <= '0;
      hiS2       <= 1'b0;
      loS2       <= 1'b0;
    end else if (strobes.advance) begin
      coarseTerm <= coarseNext;
      fineTerm   <= fineNext;
      hiS2       <= hiS1;
      loS2       <= loS1;
    end
  end

  // Stage 3: merge. A fine term below zero borrows from the coarse step, and one past it carries.
  logic signed [SUM_W-1:0] sumS3;
  logic                    hiS3, loS3;

  always_ff @(posedge clk) begin
    if (rst) begin
      sumS3 <= '0;
      hiS3  <= 1'b0;
      loS3  <= 1'b0;
    end else if (strobes.advance) begin
      sumS3 <= coarseTerm + fineTerm;
      hiS3  <= hiS2;
      loS3  <= loS2;
    end
  end

  // Stage 4: saturate to the rails; the flag is registered together with the word.
  logic [OUT_W-1:0] satWord;
  logic             satOor;

  always_comb begin
    satWord = sumS3[OUT_W-1:0];
    satOor  = 1'b0;
    if (hiS3) begin
      satWord = POS_RAIL;
      satOor  = 1'b1;
    end else if (loS3) begin
      satWord = NEG_RAIL;
      satOor  = 1'b1;
    end else if (sumS3 > TOP_VAL) begin
      satWord = POS_RAIL;
      satOor  = 1'b1;
    end else if (sumS3 < BOT_VAL) begin
      satWord = NEG_RAIL;
      satOor  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ <= '0;
      oorQ  <= 1'b0;
    end else if (strobes.advance) begin
      wordQ <= satWord;
      oorQ  <= satOor;
    end
  end

  // R7: a stopped clock freezes the output stage
  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.advance |=> ($stable(wordQ) && $stable(oorQ)));

  // R3: the high comparator forces the positive rail whatever the arithmetic gives
  p_over_rail_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && hiS3) |=> (oorQ && wordQ == POS_RAIL));

  // R5: an in-range merged value never raises the flag
  p_in_range_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && !hiS3 && !loS3 && sumS3 <= TOP_VAL && sumS3 >= BOT_VAL)
      |=> !oorQ);

endmodule

// File: rtl/subrange_corrector.sv
module subrange_corrector
  import subrange_pkg::*;
#(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 6,
  localparam int OUT_W   = COARSE_W + FINE_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clkEn,
  input  logic [COARSE_W-1:0] coarseCode,
  input  logic [FINE_W-1:0]   fineCode,
  input  logic                overRange,
  input  logic                underRange,
  input  logic                offsetBin,
  output logic [OUT_W-1:0]    dataOut,
  output logic                oorOut,
  output logic                validOut
);

  localparam logic [OUT_W-1:0] SIGN_MASK = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] POS_RAIL  = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_RAIL  = {1'b1, {(OUT_W-1){1'b0}}};

  strobe_t          strobes;
  logic [OUT_W-1:0] word;
  logic             oorFlag;
  logic             resultValid;

  subrange_ctrl #(
    .DEPTH(PIPE_STAGES)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .clkEn       (clkEn),
    .strobes     (strobes),
    .resultValid (resultValid)
  );

  subrange_datapath #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .coarseIn (coarseCode),
    .fineIn   (fineCode),
    .overIn   (overRange),
    .underIn  (underRange),
    .wordQ    (word),
    .oorQ     (oorFlag)
  );

  // Stale contents never leave the block; the mode bit flips the sign bit only.
  assign validOut = resultValid;
  assign dataOut  = resultValid ? (word ^ (offsetBin ? SIGN_MASK : '0)) : '0;
  assign oorOut   = resultValid & oorFlag;

  // R5: a raised flag always comes with a rail code
  p_oor_at_rail_r5: assert property (@(posedge clk) disable iff (rst)
    oorOut |-> ((dataOut ^ (offsetBin ? SIGN_MASK : '0)) == POS_RAIL ||
                (dataOut ^ (offsetBin ? SIGN_MASK : '0)) == NEG_RAIL));

endmodule

// File: tb/tb_subrange_corrector.sv
module tb_subrange_corrector;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int HIST       = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clkEn = 1'b0;
  logic [4:0] coarseCode = '0;
  logic [5:0] fineCode = '0;
  logic       overRange = 1'b0;
  logic       underRange = 1'b0;
  logic       offsetBin = 1'b0;
  logic [9:0] dataOut;
  logic       oorOut;
  logic       validOut;

  int errors = 0;
  int checks = 0;
  int edgeCount = 0;
  int runLen = 0;
  bit stalled = 0;

  logic [9:0] expWord [HIST];
  logic       expOor  [HIST];
  string      expTag  [HIST];

  subrange_corrector dut (
    .clk        (clk),
    .rst        (rst),
    .clkEn      (clkEn),
    .coarseCode (coarseCode),
    .fineCode   (fineCode),
    .overRange  (overRange),
    .underRange (underRange),
    .offsetBin  (offsetBin),
    .dataOut    (dataOut),
    .oorOut     (oorOut),
    .validOut   (validOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected {oor, word} from the requirements.
  function automatic logic [10:0] refResult(int c, int f, bit hi, bit lo);
    int v;
    v = c * 32 + f - 16 - 512;
    if (hi)        return {1'b1, 10'h1FF};
    if (lo)        return {1'b1, 10'h200};
    if (v > 511)   return {1'b1, 10'h1FF};
    if (v < -512)  return {1'b1, 10'h200};
    return {1'b0, 10'(v)};
  endfunction

  function automatic string autoTag(int c, int f, bit hi, bit lo);
    int v;
    v = c * 32 + f - 16 - 512;
    if (hi) return "R3";
    if (lo) return "R4";
    if (v > 511 || v < -512) return "R5";
    return "R1 R2";
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic compare(string tag, logic ev, logic eo, logic [9:0] ew);
    checks++;
    if (validOut !== ev || oorOut !== eo || dataOut !== ew) begin
      errors++;
      $display("FAIL %s: valid/oor/data got %b/%b/%h expected %b/%b/%h",
               tag, validOut, oorOut, dataOut, ev, eo, ew);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic stepCycle(int c, int f, bit hi, bit lo, bit en, bit mode, string tag);
    int idx;
    coarseCode = 5'(c);
    fineCode   = 6'(f);
    overRange  = hi;
    underRange = lo;
    clkEn      = en;
    offsetBin  = mode;
    @(posedge clk);
    if (en) begin
      logic [10:0] r;
      edgeCount++;
      r = refResult(c, f, hi, lo);
      expOor[edgeCount % HIST]  = r[10];
      expWord[edgeCount % HIST] = r[9:0];
      expTag[edgeCount % HIST]  = (tag == "") ? autoTag(c, f, hi, lo) : tag;
      if (runLen < 1000) runLen++;
    end else begin
      runLen  = 0;
      stalled = 1;
    end
    @(negedge clk);
    if (runLen >= 4) begin
      idx = (edgeCount - 3) % HIST;
      compare(mode ? {expTag[idx], " R10"} : expTag[idx], 1'b1, expOor[idx],
              expWord[idx] ^ {mode, 9'b0});
    end else begin
      compare(runLen == 0 ? (stalled ? "R7" : "R9") : "R8", 1'b0, 1'b0, 10'h000);
    end
  endtask

  task automatic doReset();
    rst   = 1'b1;
    clkEn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    compare("R9", 1'b0, 1'b0, 10'h000);
    rst     = 1'b0;
    runLen  = 0;
    stalled = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): run did not finish");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();

    // Fill after reset, then directed values (R1, R2)
    stepCycle(16, 16, 0, 0, 1, 0, "R1 R2");   // 0x000
    stepCycle(16, 17, 0, 0, 1, 0, "R1 R2");   // +1
    stepCycle(16, 15, 0, 0, 1, 0, "R1 R2");   // -1
    stepCycle(15, 48, 0, 0, 1, 0, "R1 R2");   // carry out of the fine stage
    stepCycle(17, 0,  0, 0, 1, 0, "R1 R2");   // borrow from the coarse step
    // Rails and end points (R5)
    stepCycle(31, 47, 0, 0, 1, 0, "R5");      // exactly 511
    stepCycle(31, 48, 0, 0, 1, 0, "R5");      // 512 clamps
    stepCycle(0, 16,  0, 0, 1, 0, "R5");      // exactly -512
    stepCycle(0, 15,  0, 0, 1, 0, "R5");      // -513 clamps
    stepCycle(31, 63, 0, 0, 1, 0, "R5");
    stepCycle(0, 0,   0, 0, 1, 0, "R5");
    // Comparator flags and recovery (R3, R4, R6)
    stepCycle(16, 16, 1, 0, 1, 0, "R3");
    stepCycle(20, 10, 0, 0, 1, 0, "R6");
    stepCycle(16, 16, 0, 1, 1, 0, "R4");
    stepCycle(8, 40,  0, 0, 1, 0, "R6");
    stepCycle(0, 0,   1, 1, 1, 0, "R3");      // both flags: over wins
    stepCycle(31, 63, 0, 1, 1, 0, "R4");      // under forces negative rail
    // Offset binary (R10)
    stepCycle(16, 16, 0, 0, 1, 1, "R10");
    stepCycle(25, 3,  0, 0, 1, 1, "R10");
    stepCycle(3, 30,  0, 0, 1, 0, "");
    stepCycle(3, 30,  0, 0, 1, 1, "");
    stepCycle(3, 30,  0, 0, 1, 1, "");
    stepCycle(3, 30,  0, 0, 1, 0, "");

    // Clock stop and restart (R7, R8)
    stepCycle(9, 9,   0, 0, 0, 0, "R7");
    stepCycle(9, 9,   1, 0, 0, 0, "R7");
    stepCycle(12, 33, 0, 0, 1, 0, "R8");      // first sample after restart
    stepCycle(13, 34, 0, 0, 1, 0, "");
    stepCycle(14, 35, 0, 0, 1, 0, "");
    stepCycle(15, 36, 0, 0, 1, 0, "");
    stepCycle(16, 37, 0, 0, 1, 0, "");
    stepCycle(2, 2,   0, 0, 1, 0, "");
    stepCycle(2, 2,   0, 0, 0, 0, "R7");      // single-cycle stall mid-run
    for (int i = 0; i < 6; i++) stepCycle(i + 4, i * 7, 0, 0, 1, 0, "");

    // Reset in mid-run (R9)
    doReset();
    for (int i = 0; i < 6; i++) stepCycle(30 - i, i * 9, 0, 0, 1, 0, "");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      stepCycle($urandom_range(0, 31), $urandom_range(0, 63),
                $urandom_range(0, 99) < 6, $urandom_range(0, 99) < 6,
                $urandom_range(0, 99) >= 7, $urandom_range(0, 3) == 0, "");
    end

    report();
    $finish;
  end

endmodule